// File: doc/BRIEF.md
# Paged Write Collector with Timed Commit

This block sits behind a serial-bus protocol engine of a byte-wide non-volatile memory. The engine hands it a start address once per write transaction, then each data byte as it is received, then a marker for the stop condition. The block collects the bytes in a 32-byte staging buffer. A page-relative offset pointer advances after every byte and wraps inside the current page. The page index never changes during a transaction.

At the stop marker, every byte position that was loaded is written into the memory array in one step. A programming phase then follows for a fixed, parameterised number of clock cycles. During that phase `busy_o` is high and the block ignores all transaction inputs. A write-protect input can veto the commit. A parameter selects what it covers: either every page, or only the pages in the top quarter of the address space. The array is a plain synchronous RAM with one read port, so its contents can be observed.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o` is low. A stop marker outside a transaction starts nothing and leaves `busy_o` low.
- R2: The start address is split into an offset field `addr_i[4:0]` and a page field `addr_i[ADDR_W-1:5]`. The first byte goes to the start offset of that page, and each following byte goes to the next offset.
- R3: After offset 31 the pointer returns to offset 0 of the same page. Bytes never land in a neighbouring page.
- R4: If more than 32 bytes arrive in one transaction, a later byte overwrites the byte buffered earlier at the same offset. The array receives the last value sent for each offset.
- R5: The array is unchanged until the stop marker. At the stop marker all buffered bytes are written in one commit, and only the offsets loaded in this transaction change.
- R6: A commit raises `busy_o` in the cycle after the stop marker is sampled, and keeps it high for exactly `PROG_CYCLES` cycles.
- R7: While `busy_o` is high, start, byte and stop inputs have no effect. This includes the last busy cycle.
- R8: With `WP_TOP_QUARTER=0` and `wp_i` high at the stop marker, nothing is written and `busy_o` stays low.
- R9: With `WP_TOP_QUARTER=1` and `wp_i` high at the stop marker, pages whose two upper page bits are `2'b11` are left unchanged and `busy_o` stays low. All other pages commit normally.
- R10: A transaction with no data bytes between start and stop starts no commit, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a write transaction; `addr_i` is sampled |
| addr_i | input | ADDR_W | Start byte address of the transaction |
| byte_valid_i | input | 1 | One received data byte on `byte_i` |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition; triggers the commit |
| wp_i | input | 1 | Write-protect level, sampled at the stop marker |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle after `rd_addr_i` |
| busy_o | output | 1 | Programming phase in progress |

## Verification
The end of a programming phase and a new transaction can fall in the same cycle. The bench lines up a start, three bytes and finally a stop so that the stop is sampled on the very edge where `busy_o` drops. It then checks that `busy_o` stays low afterwards and that the targeted page still holds its earlier contents. A fresh transaction issued right after this must still commit normally.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pwb_tracker.sv
module pwb_tracker #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - OFS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  byte_valid_i,
  input  logic                  stop_i,
  output logic [PAGE_W-1:0]     page_o,
  output logic [OFS_W-1:0]      ptr_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic                  active_o,
  output logic                  byte_we_o,
  output logic                  stop_o
);
  logic                  active_q;
  logic [PAGE_W-1:0]     page_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  take_start, take_byte, take_stop;

  // start has priority over stop and data
  assign take_start = accept_i && start_i;
  assign take_stop  = accept_i && active_q && stop_i && !start_i;
  assign take_byte  = accept_i && active_q && byte_valid_i && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      page_q   <= '0;
      ptr_q    <= '0;
      mask_q   <= '0;
    end else if (take_start) begin
      active_q <= 1'b1;
      page_q   <= addr_i[ADDR_W-1:OFS_W];
      ptr_q    <= addr_i[OFS_W-1:0];
      mask_q   <= '0;
    end else if (take_stop) begin
      active_q <= 1'b0;
    end else if (take_byte) begin
      ptr_q         <= ptr_q + 1'b1;
      mask_q[ptr_q] <= 1'b1;
    end
  end

  assign page_o    = page_q;
  assign ptr_o     = ptr_q;
  assign mask_o    = mask_q;
  assign active_o  = active_q;
  assign byte_we_o = take_byte;
  assign stop_o    = take_stop;

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_byte |=> $stable(page_q)); // R3
  AST_SLOT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_byte |=> mask_q[$past(ptr_q)]); // R2
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic                         clk_i,
  input  logic                         we_i,
  input  logic [OFS_W-1:0]             idx_i,
  input  byte_t                        data_i,
  output logic [PAGE_BYTES*BYTE_W-1:0] page_o
);
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_slot
    byte_t slot_q;
    always_ff @(posedge clk_i) begin
      if (we_i && idx_i == OFS_W'(b)) slot_q <= data_i;
    end
    assign page_o[b*BYTE_W +: BYTE_W] = slot_q;
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int PROG_CYCLES = 20,
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CNT_W'(PROG_CYCLES)); // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i); // R7
endmodule

// File: rtl/pwb_array.sv
module pwb_array
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - OFS_W,
  parameter int PAGES      = 2 ** PAGE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [PAGE_W-1:0]            wpage_i,
  input  logic [PAGE_BYTES*BYTE_W-1:0] wdata_i,
  input  logic [PAGE_BYTES-1:0]        wbe_i,
  input  logic [ADDR_W-1:0]            raddr_i,
  output byte_t                        rdata_o
);
  logic [PAGE_BYTES*BYTE_W-1:0] lanes_rd;
  logic [OFS_W-1:0]             roff_q;

  // one RAM per byte lane so a whole page commits in one edge
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
    byte_t mem_q [PAGES];
    byte_t rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[b]) mem_q[wpage_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      rd_q <= mem_q[raddr_i[ADDR_W-1:OFS_W]];
    end
    assign lanes_rd[b*BYTE_W +: BYTE_W] = rd_q;
  end

  always_ff @(posedge clk_i) roff_q <= raddr_i[OFS_W-1:0];

  assign rdata_o = lanes_rd[roff_q*BYTE_W +: BYTE_W];

  AST_COMMIT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (|wbe_i)); // R10
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int PAGE_BYTES     = 32,
  parameter int PROG_CYCLES    = 20,
  parameter bit WP_TOP_QUARTER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0]            page;
  logic [OFS_W-1:0]             ptr;
  logic [PAGE_BYTES-1:0]        mask;
  logic [PAGE_BYTES*BYTE_W-1:0] staged;
  logic                         active, byte_we, stop_take;
  logic                         blocked, commit, busy, top_page;

  pwb_tracker #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W), .PAGE_W(PAGE_W)
  ) i_tracker (
    .clk_i, .rst_ni,
    .accept_i    (!busy),
    .start_i, .addr_i, .byte_valid_i, .stop_i,
    .page_o      (page),
    .ptr_o       (ptr),
    .mask_o      (mask),
    .active_o    (active),
    .byte_we_o   (byte_we),
    .stop_o      (stop_take)
  );

  pwb_buffer #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) i_buffer (
    .clk_i,
    .we_i   (byte_we),
    .idx_i  (ptr),
    .data_i (byte_i),
    .page_o (staged)
  );

  assign top_page = (page[PAGE_W-1 -: 2] == 2'b11);

  if (WP_TOP_QUARTER) begin : g_wp_top
    assign blocked = wp_i && top_page;
  end else begin : g_wp_all
    assign blocked = wp_i;
  end

  assign commit = stop_take && (|mask) && !blocked;

  pwb_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i, .rst_ni,
    .start_i (commit),
    .busy_o  (busy)
  );

  pwb_array #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W), .PAGE_W(PAGE_W)
  ) i_array (
    .clk_i, .rst_ni,
    .we_i    (commit),
    .wpage_i (page),
    .wdata_i (staged),
    .wbe_i   (mask),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign busy_o = busy;

  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R6
  AST_IDLE_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !active); // R7
  AST_WP_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WP_TOP_QUARTER && wp_i && stop_take) |=> !busy_o); // R8
  AST_WP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && top_page && stop_take) |=> !busy_o); // R9
  AST_EMPTY_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_take && mask == '0) |=> !busy_o); // R10
endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int CLK_P = 10;
  localparam int AW    = 12;
  localparam int PROG  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bval = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0] bdata = '0, rd0, rd1;
  logic busy0, busy1;
  logic [7:0] m0 [4096];
  logic [7:0] m1 [4096];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .PROG_CYCLES(PROG), .WP_TOP_QUARTER(1'b0)) i_page_write_buffer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .byte_valid_i(bval),
    .byte_i(bdata), .stop_i(stop), .wp_i(wp), .rd_addr_i(rd_addr), .rd_data_o(rd0), .busy_o(busy0));

  page_write_buffer #(.ADDR_W(AW), .PROG_CYCLES(PROG), .WP_TOP_QUARTER(1'b1)) i_page_write_buffer_tq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .byte_valid_i(bval),
    .byte_i(bdata), .stop_i(stop), .wp_i(wp), .rd_addr_i(rd_addr), .rd_data_o(rd1), .busy_o(busy1));

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // primitives: called at a negedge, hold one cycle
  task automatic p_start(input logic [AW-1:0] a);
    start = 1'b1; addr = a; @(negedge clk); start = 1'b0;
  endtask
  task automatic p_byte(input logic [7:0] d);
    bval = 1'b1; bdata = d; @(negedge clk); bval = 1'b0;
  endtask
  task automatic p_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy0 || busy1) @(negedge clk);
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d0, output logic [7:0] d1);
    rd_addr = a; @(negedge clk); d0 = rd0; d1 = rd1;
  endtask

  task automatic model_upd(input logic [AW-1:0] a, input int n, input logic [7:0] seed, input bit wpv);
    bit b0 = wpv;
    bit b1 = wpv && (a[AW-1:AW-2] == 2'b11);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] t = {a[AW-1:5], 5'((a[4:0] + i) % 32)};
      if (!b0) m0[t] = seed + 8'(i);
      if (!b1) m1[t] = seed + 8'(i);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input logic [7:0] seed, input bit wpv);
    wp = wpv;
    p_start(a);
    for (int i = 0; i < n; i++) p_byte(seed + 8'(i));
    p_stop();
    model_upd(a, n, seed, wpv);
    wait_idle();
    wp = 1'b0;
  endtask

  task automatic check_page(input logic [AW-6:0] pg, input string tag);
    int e0 = 0, e1 = 0;
    logic [7:0] a0 = '0, a1 = '0, x0 = '0, x1 = '0;
    for (int o = 0; o < 32; o++) begin
      logic [7:0] d0, d1;
      logic [AW-1:0] t = {pg, 5'(o)};
      rd(t, d0, d1);
      if (d0 !== m0[t] && e0 == 0) begin a0 = d0; x0 = m0[t]; end
      if (d1 !== m1[t] && e1 == 0) begin a1 = d1; x1 = m1[t]; end
      if (d0 !== m0[t]) e0++;
      if (d1 !== m1[t]) e1++;
    end
    check(a0, x0, {tag, " whole-array variant"});
    check(a1, x1, {tag, " top-quarter variant"});
  endtask

  task automatic t_reset();
    check(busy0, 0, "R1 busy after reset");
    p_stop(); @(negedge clk);
    check(busy0, 0, "R1 stray stop");
  endtask

  task automatic t_fill();
    int cnt = 0;
    p_start(12'h060);
    for (int i = 0; i < 32; i++) p_byte(8'h10 + 8'(i));
    p_stop();
    model_upd(12'h060, 32, 8'h10, 1'b0);
    while (busy0 && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt, PROG, "R6 busy length");
    wait_idle();
    do_write(12'h080, 32, 8'h40, 1'b0);
    do_write(12'h0A0, 32, 8'h70, 1'b0);
    do_write(12'hC00, 32, 8'hA0, 1'b0);
    check_page(7'h03, "R2 full page");
  endtask

  task automatic t_partial();
    logic [7:0] d0, d1;
    p_start(12'h065);
    for (int i = 0; i < 4; i++) p_byte(8'hC0 + 8'(i));
    rd(12'h065, d0, d1);
    check(d0, 8'h15, "R5 array unchanged before stop");
    p_stop();
    model_upd(12'h065, 4, 8'hC0, 1'b0);
    wait_idle();
    check_page(7'h03, "R5 partial commit");
  endtask

  task automatic t_wrap();
    do_write(12'h07E, 5, 8'h55, 1'b0);
    check_page(7'h03, "R3 wrap within page");
    check_page(7'h04, "R3 neighbour page untouched");
  endtask

  task automatic t_overflow();
    do_write(12'h060, 40, 8'h00, 1'b0);
    check_page(7'h03, "R4 overflow overwrite");
  endtask

  task automatic t_empty();
    p_start(12'h060); p_stop();
    check(busy0, 0, "R10 empty transaction");
    @(negedge clk);
    check(busy1, 0, "R10 empty transaction tq");
  endtask

  task automatic t_busy_ignore();
    p_start(12'h061); p_byte(8'hEE); p_stop();
    model_upd(12'h061, 1, 8'hEE, 1'b0);
    p_start(12'h0A0);
    p_byte(8'h01); p_byte(8'h02); p_byte(8'h03);
    repeat (PROG - 5) @(negedge clk);
    check(busy0, 1, "R7 still busy in last cycle");
    p_stop();
    check(busy0, 0, "R7 busy dropped");
    @(negedge clk);
    check(busy0, 0, "R7 stop in last busy cycle ignored");
    check_page(7'h05, "R7 page untouched");
    do_write(12'h0A2, 2, 8'h33, 1'b0);
    check_page(7'h05, "R7 next transaction accepted");
  endtask

  task automatic t_wp_low();
    wp = 1'b1;
    p_start(12'h068); p_byte(8'h99); p_stop();
    model_upd(12'h068, 1, 8'h99, 1'b1);
    check(busy0, 0, "R8 protected, no busy");
    check(busy1, 1, "R9 lower page commits");
    wait_idle(); wp = 1'b0;
    check_page(7'h03, "R8 R9 low page");
  endtask

  task automatic t_wp_top();
    wp = 1'b1;
    p_start(12'hC03); p_byte(8'h11); p_stop();
    model_upd(12'hC03, 1, 8'h11, 1'b1);
    check(busy0, 0, "R8 top page no busy");
    check(busy1, 0, "R9 top page no busy");
    wait_idle(); wp = 1'b0;
    check_page(7'h60, "R9 top page protected");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_partial();
    t_wrap();
    t_overflow();
    t_empty();
    t_busy_ignore();
    t_wp_low();
    t_wp_top();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule